// File: doc/BRIEF.md
# Data Segment Load Protection Checker

This block decides whether a selector may be loaded into a data segment register or into the stack segment register of a protected-mode processor. The descriptor has already been fetched and decoded elsewhere. The caller raises a one-cycle strobe with the following inputs:

- the kind of register being loaded;
- the privilege requested by the selector;
- the current privilege level;
- the decoded descriptor bits: null selector, system descriptor, code or data, readable/writable, conforming, present, and descriptor privilege.

One clock later the block pulses `done`. It raises either `accept` or `fault`, and when it faults it gives the exception vector number.

Privilege levels are 2-bit values, and 0 is the most privileged. The stack register and the other data registers follow different rules. For each kind of register, type and privilege violations are reported ahead of a missing segment. The block does not fetch descriptors, load the segment cache or check limits.

Top module: `dseg_load_guard`

## Requirements
- R1: After a synchronous active-low reset, `done`, `accept`, `fault` and `vector` are all zero.
- R2: A strobe taken at one rising edge produces `done` high for exactly the following cycle. `accept`, `fault` and `vector` are zero whenever `done` is low.
- R3: A strobe presented while `done` is high is ignored and produces no result.
- R4: A stack load with a null selector, a system descriptor, a code descriptor or a read-only data descriptor faults with vector 13.
- R5: A stack load of a writable data segment whose descriptor privilege or requested privilege differs from the current privilege faults with vector 13. This applies even when the segment is absent.
- R6: A stack load that passes R4 and R5 but has the present bit clear faults with vector 12. If the present bit is set, the load is accepted.
- R7: A non-stack load naming a system descriptor or an execute-only code segment faults with vector 13. This applies even when the segment is absent.
- R8: A non-stack load of a data segment or of a non-conforming readable code segment faults with vector 13 unless max(current, requested) <= descriptor privilege. A conforming readable code segment is exempt from this test.
- R9: A non-stack load that passes R7 and R8 but has the present bit clear faults with vector 11.
- R10: A non-stack load with a null selector is accepted whatever the other descriptor bits say.
- R11: When `done` is high, exactly one of `accept` and `fault` is high, and `vector` is 0 on accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| tgt_stack | input | 1 | 1 = stack segment register, 0 = other data register |
| sel_rpl | input | 2 | Requested privilege from the selector |
| cur_cpl | input | 2 | Current privilege level |
| d_null | input | 1 | Selector is null |
| d_system | input | 1 | Descriptor is a system descriptor |
| d_code | input | 1 | 1 = code segment, 0 = data segment |
| d_rw | input | 1 | Readable (code) or writable (data) |
| d_conforming | input | 1 | Code segment is conforming |
| d_present | input | 1 | Segment present bit |
| d_dpl | input | 2 | Descriptor privilege |
| done | output | 1 | Result valid pulse |
| accept | output | 1 | Load allowed |
| fault | output | 1 | Load refused |
| vector | output | 8 | Exception vector number, 0 on accept |

## Verification
The bench builds the block with its default parameters: an 8-bit vector and the vector numbers 13, 12 and 11. Each fault class therefore shows up as its own vector value, so a wrong priority between the type, privilege and presence tests appears directly at the port. The cases place the three privilege values on both sides of each comparison, including max(current, requested) landing exactly on the descriptor privilege. They also put absent descriptors behind illegal type or privilege settings.

// File: rtl/dsl_pkg.sv
// Package: shared cause encoding and privilege width for the data segment
// load checker. Assumes 2-bit privilege levels, 0 most privileged.
package dsl_pkg;
    localparam int PL_W = 2;

    typedef enum logic [1:0] {
        CAUSE_NONE         = 2'd0,
        CAUSE_PROT         = 2'd1,
        CAUSE_STACK_ABSENT = 2'd2,
        CAUSE_ABSENT       = 2'd3
    } cause_e;
endpackage

// File: rtl/dsl_stack_rules.sv
// Module: stack register rules. Combinational.
// Needs a present, writable data segment with descriptor and requested
// privilege both equal to the current level. Type and privilege are
// judged before presence.
module dsl_stack_rules
    import dsl_pkg::*;
(
    input  logic            is_null,
    input  logic            is_system,
    input  logic            is_code,
    input  logic            rw,
    input  logic            present,
    input  logic [PL_W-1:0] dpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] cpl,
    output cause_e          cause
);
    logic type_ok;
    logic priv_ok;

    // Type test: only a writable data segment may back the stack.
    always_comb type_ok = !is_null && !is_system && !is_code && rw;

    // Privilege test: exact match on both levels.
    always_comb priv_ok = (dpl == cpl) && (rpl == cpl);

    // Verdict in priority order.
    always_comb begin
        if (!type_ok || !priv_ok)
            cause = CAUSE_PROT;
        else if (!present)
            cause = CAUSE_STACK_ABSENT;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/dsl_data_rules.sv
// Module: rules for non-stack data registers. Combinational.
// A null selector is always accepted. System descriptors and
// execute-only code are refused. Data and non-conforming code need
// max(cpl, rpl) <= dpl. Presence is judged last.
module dsl_data_rules
    import dsl_pkg::*;
(
    input  logic            is_null,
    input  logic            is_system,
    input  logic            is_code,
    input  logic            rw,
    input  logic            conforming,
    input  logic            present,
    input  logic [PL_W-1:0] dpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] cpl,
    output cause_e          cause
);
    logic [PL_W-1:0] eff_pl;
    logic            type_ok;
    logic            priv_exempt;
    logic            priv_ok;

    // Effective privilege is the weaker (numerically larger) of the two.
    always_comb eff_pl = (cpl > rpl) ? cpl : rpl;

    // Type test: no system descriptor and no execute-only code.
    always_comb type_ok = !is_system && !(is_code && !rw);

    // Conforming readable code skips the privilege comparison.
    always_comb priv_exempt = is_code && conforming;

    // Privilege test against the descriptor level.
    always_comb priv_ok = priv_exempt || (eff_pl <= dpl);

    // Verdict in priority order.
    always_comb begin
        if (is_null)
            cause = CAUSE_NONE;
        else if (!type_ok || !priv_ok)
            cause = CAUSE_PROT;
        else if (!present)
            cause = CAUSE_ABSENT;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/dsl_result_reg.sv
// Module: result register. Captures a cause when take is high and shows
// it for one cycle with done. Outputs are all zero when done is low.
module dsl_result_reg
    import dsl_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int VEC_PROT  = 13,
    parameter int VEC_STACK = 12,
    parameter int VEC_ABS   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  cause_e           cause,
    output logic             done,
    output logic             accept,
    output logic             fault,
    output logic [VEC_W-1:0] vector
);
    logic [VEC_W-1:0] vec_next;

    // Map the cause to its exception number.
    always_comb begin
        unique case (cause)
            CAUSE_PROT:         vec_next = VEC_W'(VEC_PROT);
            CAUSE_STACK_ABSENT: vec_next = VEC_W'(VEC_STACK);
            CAUSE_ABSENT:       vec_next = VEC_W'(VEC_ABS);
            default:            vec_next = '0;
        endcase
    end

    // Register the verdict for a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            done   <= 1'b0;
            accept <= 1'b0;
            fault  <= 1'b0;
            vector <= '0;
        end else begin
            done   <= 1'b1;
            accept <= (cause == CAUSE_NONE);
            fault  <= (cause != CAUSE_NONE);
            vector <= vec_next;
        end
    end
endmodule

// File: rtl/dseg_load_guard.sv
// Module: top of the data segment load checker.
// Runs the stack and non-stack rule sets in parallel and keeps the one
// that matches the target register. The result appears one cycle after
// the strobe. A strobe arriving while a result is shown is dropped.
module dseg_load_guard
    import dsl_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int VEC_PROT  = 13,
    parameter int VEC_STACK = 12,
    parameter int VEC_ABS   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             tgt_stack,
    input  logic [PL_W-1:0]  sel_rpl,
    input  logic [PL_W-1:0]  cur_cpl,
    input  logic             d_null,
    input  logic             d_system,
    input  logic             d_code,
    input  logic             d_rw,
    input  logic             d_conforming,
    input  logic             d_present,
    input  logic [PL_W-1:0]  d_dpl,
    output logic             done,
    output logic             accept,
    output logic             fault,
    output logic [VEC_W-1:0] vector
);
    cause_e stack_cause;
    cause_e data_cause;
    cause_e sel_cause;
    logic   take;

    dsl_stack_rules u_stack (
        .is_null   (d_null),
        .is_system (d_system),
        .is_code   (d_code),
        .rw        (d_rw),
        .present   (d_present),
        .dpl       (d_dpl),
        .rpl       (sel_rpl),
        .cpl       (cur_cpl),
        .cause     (stack_cause)
    );

    dsl_data_rules u_data (
        .is_null    (d_null),
        .is_system  (d_system),
        .is_code    (d_code),
        .rw         (d_rw),
        .conforming (d_conforming),
        .present    (d_present),
        .dpl        (d_dpl),
        .rpl        (sel_rpl),
        .cpl        (cur_cpl),
        .cause      (data_cause)
    );

    // Pick the rule set for the target register.
    always_comb sel_cause = tgt_stack ? stack_cause : data_cause;

    // Accept a strobe only when no result is being shown.
    always_comb take = req_valid && !done;

    dsl_result_reg #(
        .VEC_W     (VEC_W),
        .VEC_PROT  (VEC_PROT),
        .VEC_STACK (VEC_STACK),
        .VEC_ABS   (VEC_ABS)
    ) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .cause  (sel_cause),
        .done   (done),
        .accept (accept),
        .fault  (fault),
        .vector (vector)
    );
endmodule

// File: rtl/dseg_load_guard_chk.sv
// Checker module: temporal properties at the ports of dseg_load_guard,
// attached by bind.
module dseg_load_guard_chk #(
    parameter int VEC_W     = 8,
    parameter int VEC_PROT  = 13,
    parameter int VEC_STACK = 12,
    parameter int VEC_ABS   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             tgt_stack,
    input logic [1:0]       sel_rpl,
    input logic [1:0]       cur_cpl,
    input logic             d_system,
    input logic             d_code,
    input logic             d_rw,
    input logic             d_present,
    input logic [1:0]       d_dpl,
    input logic             done,
    input logic             accept,
    input logic             fault,
    input logic [VEC_W-1:0] vector
);
    // R2
    strobe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !done) |=> done);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!accept && !fault && vector == '0));
    // R3
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid) |=> !done);
    // R11
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({accept, fault}) == 1);
    // R11
    accept_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && accept) |-> vector == '0);
    // R4
    stack_accept_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !done && tgt_stack && (d_system || d_code || !d_rw)) |=> fault);
    // R5
    stack_accept_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !done && tgt_stack && (d_dpl != cur_cpl || sel_rpl != cur_cpl))
        |=> (fault && vector == VEC_W'(VEC_PROT)));
    // R6
    stack_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vector == VEC_W'(VEC_STACK)) |-> $past(tgt_stack && !d_present));
    // R9
    data_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vector == VEC_W'(VEC_ABS)) |-> $past(!tgt_stack && !d_present));
endmodule

bind dseg_load_guard dseg_load_guard_chk #(
    .VEC_W     (VEC_W),
    .VEC_PROT  (VEC_PROT),
    .VEC_STACK (VEC_STACK),
    .VEC_ABS   (VEC_ABS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .tgt_stack (tgt_stack),
    .sel_rpl   (sel_rpl),
    .cur_cpl   (cur_cpl),
    .d_system  (d_system),
    .d_code    (d_code),
    .d_rw      (d_rw),
    .d_present (d_present),
    .d_dpl     (d_dpl),
    .done      (done),
    .accept    (accept),
    .fault     (fault),
    .vector    (vector)
);

// File: tb/sim_dseg_load_guard.sv
// Bench: a vector table walked by one loop, then directed reset, pulse
// width and busy-drop tests.
module sim_dseg_load_guard;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    // Entry layout: {stk,nul,sys,cod,rw,cnf,prs,dpl[2],rpl[2],cpl[2],vec[8],req[4]}
    function automatic logic [24:0] mk(input logic stk, nul, sys, cod, rw, cnf, prs,
                                       input logic [1:0] dpl, rpl, cpl,
                                       input logic [7:0] vec, input logic [3:0] req);
        return {stk, nul, sys, cod, rw, cnf, prs, dpl, rpl, cpl, vec, req};
    endfunction

    localparam int NV = 22;
    localparam logic [24:0] TBL [NV] = '{
        mk(1,0,0,0,1,0,1, 2'd0,2'd0,2'd0,  8'd0, 4'd6),  // R6 accept at level 0
        mk(1,0,0,0,1,0,1, 2'd3,2'd3,2'd3,  8'd0, 4'd6),  // R6 accept at level 3
        mk(1,0,0,0,0,0,1, 2'd1,2'd1,2'd1, 8'd13, 4'd4),  // R4 read-only data
        mk(1,0,0,1,1,0,1, 2'd1,2'd1,2'd1, 8'd13, 4'd4),  // R4 code
        mk(1,0,1,0,1,0,1, 2'd1,2'd1,2'd1, 8'd13, 4'd4),  // R4 system
        mk(1,1,0,0,1,0,1, 2'd0,2'd0,2'd0, 8'd13, 4'd4),  // R4 null
        mk(1,0,0,0,1,0,1, 2'd2,2'd1,2'd1, 8'd13, 4'd5),  // R5 dpl differs
        mk(1,0,0,0,1,0,1, 2'd1,2'd2,2'd1, 8'd13, 4'd5),  // R5 rpl differs
        mk(1,0,0,0,1,0,0, 2'd2,2'd2,2'd2, 8'd12, 4'd6),  // R6 absent
        mk(1,0,0,0,1,0,0, 2'd0,2'd1,2'd1, 8'd13, 4'd5),  // R5 beats absent
        mk(0,0,0,0,1,0,1, 2'd0,2'd0,2'd0,  8'd0, 4'd8),  // R8 equal levels
        mk(0,0,0,0,0,0,1, 2'd2,2'd2,2'd1,  8'd0, 4'd8),  // R8 max hits dpl
        mk(0,0,0,0,1,0,1, 2'd1,2'd0,2'd2, 8'd13, 4'd8),  // R8 cpl too weak
        mk(0,0,0,0,1,0,1, 2'd2,2'd3,2'd0, 8'd13, 4'd8),  // R8 rpl too weak
        mk(0,0,0,1,1,0,1, 2'd0,2'd0,2'd3, 8'd13, 4'd8),  // R8 nonconforming code
        mk(0,0,0,1,1,1,1, 2'd0,2'd3,2'd3,  8'd0, 4'd8),  // R8 conforming exempt
        mk(0,0,0,1,0,0,1, 2'd3,2'd0,2'd0, 8'd13, 4'd7),  // R7 execute-only
        mk(0,0,1,0,1,0,1, 2'd3,2'd0,2'd0, 8'd13, 4'd7),  // R7 system
        mk(0,1,1,0,0,0,0, 2'd0,2'd3,2'd3,  8'd0, 4'd10), // R10 null ignores bits
        mk(0,0,0,0,1,0,0, 2'd3,2'd1,2'd1, 8'd11, 4'd9),  // R9 absent
        mk(0,0,0,1,0,0,0, 2'd3,2'd0,2'd0, 8'd13, 4'd7),  // R7 beats absent
        mk(0,0,0,0,1,0,1, 2'd3,2'd1,2'd1,  8'd0, 4'd8)   // R8 dpl weaker
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       tgt_stack = 1'b0;
    logic [1:0] sel_rpl = '0, cur_cpl = '0, d_dpl = '0;
    logic       d_null = 1'b0, d_system = 1'b0, d_code = 1'b0, d_rw = 1'b0;
    logic       d_conforming = 1'b0, d_present = 1'b0;
    logic       done, accept, fault;
    logic [7:0] vector;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cycles = 0;

    dseg_load_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tgt_stack(tgt_stack),
        .sel_rpl(sel_rpl), .cur_cpl(cur_cpl), .d_null(d_null), .d_system(d_system),
        .d_code(d_code), .d_rw(d_rw), .d_conforming(d_conforming),
        .d_present(d_present), .d_dpl(d_dpl), .done(done), .accept(accept),
        .fault(fault), .vector(vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    task automatic drive(input logic [24:0] e);
        {tgt_stack, d_null, d_system, d_code, d_rw, d_conforming, d_present,
         d_dpl, sel_rpl, cur_cpl} = e[24:12];
    endtask

    task automatic check(input string tag, input logic d, a, f, input logic [7:0] v);
        n_chk = n_chk + 1;
        if (done !== d || accept !== a || fault !== f || vector !== v) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual done=%b acc=%b flt=%b vec=%0d expected done=%b acc=%b flt=%b vec=%0d",
                     tag, done, accept, fault, vector, d, a, f, v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", 1'b0, 1'b0, 1'b0, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R%0d row %0d", TBL[i][3:0], i), 1'b1,
                  TBL[i][11:4] == 8'd0, TBL[i][11:4] != 8'd0, TBL[i][11:4]);
            @(negedge clk);
        end

        // R2 the result lasts one cycle and clears the outputs afterwards
        drive(TBL[8]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 pulse", 1'b1, 1'b0, 1'b1, 8'd12);
        @(negedge clk);
        check("R2 after", 1'b0, 1'b0, 1'b0, 8'd0);

        // R3 a back-to-back strobe is dropped
        drive(TBL[0]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R3 first", 1'b1, 1'b1, 1'b0, 8'd0);
        drive(TBL[19]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 dropped", 1'b0, 1'b0, 1'b0, 8'd0);
        @(negedge clk);
        check("R3 idle", 1'b0, 1'b0, 1'b0, 8'd0);

        // R1 reset in the middle of a result
        drive(TBL[2]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid", 1'b0, 1'b0, 1'b0, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule